// File: doc/BRIEF.md
# Reloading Down-Count Timer

This block is a 32-bit down counter behind a byte-wide register window. Software writes a reload value one byte at a time, then issues a load command that copies it into the live counter. Each qualified tick pulse lowers the counter by one. A tick that arrives while the counter is zero brings back the reload value instead, so counting never stops. Reading a count byte returns the matching byte of the live counter, not the stored reload value.

After reset the timer is in a test mode. In that mode a run bit in the command register gates the tick, so the counter can be held still, preset and then released. Setting the operate bit leaves test mode. From then on every tick counts, whatever the run bit holds, and only a reset brings test mode back. Producing the tick and raising any interrupt are the job of neighbouring logic.

Top module: `tick_timer`

## Requirements
- R1: After reset the live count and the reload value are zero, the block is in test mode with the run bit clear, and the command register reads 0x10.
- R2: Writing a count byte changes only that byte of the reload value. The live count does not change.
- R3: Reads at offsets 1, 2, 3 and 4 return live count bits 7:0, 15:8, 23:16 and 31:24. Offset 0 is the command register. Reads at offsets 5 to 7 return 0.
- R4: Writing the command register with bit 4 set makes the live count equal to the reload value on the next cycle. With bit 4 clear, a command write does not touch the count. Bit 4 always reads as 1.
- R5: In test mode with command bit 1 clear, ticks are ignored and the count holds. With bit 1 set, ticks are counted.
- R6: Each counted tick while the count is nonzero lowers the count by exactly one.
- R7: A counted tick while the count is zero loads the reload value, so one full period lasts reload+1 ticks.
- R8: Writing 1 to command bit 0 selects operational mode. After that, writing 0 to bit 0 is ignored, and only reset clears the bit. Bit 0 reads back the mode (1 = operational).
- R9: In operational mode every tick is counted, regardless of command bit 1.
- R10: The command register reads as {3'b000, 1'b1, 2'b00, run bit, operate bit}. The unused bits read 0.
- R11: When a load command and a tick fall in the same cycle, the load wins and the count takes the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 3 | Register offset: 0 command, 1 to 4 count bytes from low to high |
| wdata_i | input | 8 | Write data |
| tick_i | input | 1 | Count-tick pulse, one cycle per tick |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| count_o | output | 32 | Live counter value |

## Verification
Read data is combinational. The bench checks it inside the access cycle, about a nanosecond after driving the address. Writes, loads and ticks all take effect one cycle later: each is sampled at a rising edge and shows on `count_o` and in the read data from that edge on. The bench drives its inputs on the falling edge. On each falling edge it compares `count_o` with its own model, which it advanced for the edge that just passed. Every comparison therefore lands on the first cycle in which the result is due.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  // command register bit positions
  localparam int unsigned CMD_OPER_BIT = 0;
  localparam int unsigned CMD_RUN_BIT  = 1;
  localparam int unsigned CMD_LOAD_BIT = 4;

  typedef struct packed {
    logic oper;
    logic run;
  } mode_t;
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs import tick_timer_pkg::*; #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NBYTE  = CNT_W / DATA_W,
  localparam int unsigned ADDR_W = $clog2(NBYTE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  reload_o,
  output mode_t             mode_o,
  output logic              load_o
);
  logic cmd_wr;
  assign cmd_wr = wr_i && (addr_i == '0);
  assign load_o = cmd_wr && wdata_i[CMD_LOAD_BIT];

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        reload_o[g*DATA_W +: DATA_W] <= '0;
      else if (wr_i && addr_i == ADDR_W'(g + 1))
        reload_o[g*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
    end else if (cmd_wr) begin
      mode_o.run  <= wdata_i[CMD_RUN_BIT];
      // one-way latch: only reset leaves operational mode
      mode_o.oper <= mode_o.oper | wdata_i[CMD_OPER_BIT];
    end
  end
endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o
);
  logic at_zero;
  assign at_zero = (count_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_o <= '0;
    else if (load_i)  count_o <= reload_i;
    else if (step_i)  count_o <= at_zero ? reload_i : count_o - CNT_W'(1);
  end
endmodule

// File: rtl/tick_timer_rdmux.sv
module tick_timer_rdmux import tick_timer_pkg::*; #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NBYTE  = CNT_W / DATA_W,
  localparam int unsigned ADDR_W = $clog2(NBYTE + 1)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  mode_t             mode_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] cmd_rd;

  always_comb begin
    cmd_rd = '0;
    cmd_rd[CMD_OPER_BIT] = mode_i.oper;
    cmd_rd[CMD_RUN_BIT]  = mode_i.run;
    cmd_rd[CMD_LOAD_BIT] = 1'b1;  // load strobe is write-only
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o = cmd_rd;
    for (int i = 0; i < NBYTE; i++)
      if (addr_i == ADDR_W'(i + 1)) rdata_o = count_i[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer import tick_timer_pkg::*; #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NBYTE  = CNT_W / DATA_W,
  localparam int unsigned ADDR_W = $clog2(NBYTE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [CNT_W-1:0] reload;
  mode_t            mode;
  logic             load_pls;
  logic             step;

  // operational mode forces the tick through; test mode gates it with run
  assign step = tick_i && (mode.oper || mode.run);

  tick_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (req_i && we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .reload_o (reload),
    .mode_o   (mode),
    .load_o   (load_pls)
  );

  tick_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_pls),
    .reload_i (reload),
    .step_i   (step),
    .count_o  (count_o)
  );

  tick_timer_rdmux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
    .addr_i  (addr_i),
    .count_i (count_o),
    .mode_i  (mode),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NBYTE  = CNT_W / DATA_W,
  localparam int unsigned ADDR_W = $clog2(NBYTE + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              tick_i,
  input logic [CNT_W-1:0]  count_o,
  input logic [CNT_W-1:0]  reload,
  input logic              oper,
  input logic              run,
  input logic              load_pls
);
  assert_load_copies_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pls |=> count_o == $past(reload));

  assert_halt_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oper && !run && !load_pls) |=> $stable(count_o));

  assert_step_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (oper || run) && !load_pls && count_o != '0)
      |=> count_o == $past(count_o) - CNT_W'(1));

  assert_wrap_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (oper || run) && !load_pls && count_o == '0)
      |=> count_o == $past(reload));

  assert_oper_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oper |=> oper);

  assert_oper_counts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oper && tick_i && !load_pls) |=> !$stable(count_o) || $past(reload) == '0);

  assert_cmd_layout_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == '0 |-> rdata_o[4] && rdata_o[7:5] == 3'b000 && rdata_o[3:2] == 2'b00);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .tick_i   (tick_i),
  .count_o  (count_o),
  .reload   (reload),
  .oper     (mode.oper),
  .run      (mode.run),
  .load_pls (load_pls)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, tick = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [31:0] count;

  int total = 0, bad = 0;
  string tag = "R1";

  // behavioural reference
  longint m_cnt = 0, m_rel = 0;
  bit m_oper = 0, m_run = 0;

  always #2 clk = ~clk;

  tick_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .tick_i(tick), .rdata_o(rdata), .count_o(count)
  );

  task automatic chk(string t, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", t, act, exp);
    end
  endtask

  // one cycle: drive at negedge, advance model for the edge, compare at next negedge
  task automatic cyc(bit r, bit w, int a, int d, bit t);
    bit load;
    req = r; we = w; addr = 3'(a); wdata = 8'(d); tick = t;
    load = r && w && a == 0 && d[4];
    if (load) m_cnt = m_rel;
    else if (t && (m_oper || m_run)) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1;
    if (r && w && a == 0) begin
      m_run = d[1];
      m_oper = m_oper | d[0];
    end else if (r && w && a >= 1 && a <= 4) begin
      m_rel[(a-1)*8 +: 8] = 8'(d);
    end
    @(negedge clk);
    req = 0; we = 0; tick = 0;
    chk(tag, count, m_cnt);
  endtask

  task automatic rd(int a, longint exp, string t);
    req = 1; we = 0; addr = 3'(a);
    #1;
    chk(t, rdata, exp);
    @(negedge clk);
    req = 0;
    chk(t, count, m_cnt);
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_cnt = 0; m_rel = 0; m_oper = 0; m_run = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", count, 0);
    rd(0, 8'h10, "R1 R10 cmd after reset");

    // R2 byte writes only change the reload value; R5 ticks held while halted
    tag = "R2";
    cyc(1, 1, 1, 8'h78, 1);
    cyc(1, 1, 2, 8'h56, 1);
    cyc(1, 1, 3, 8'h34, 0);
    cyc(1, 1, 4, 8'h12, 1);
    chk("R2", count, 0);
    tag = "R5";
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1);
    chk("R5 halted", count, 0);

    // R4 load bit clear does nothing, set copies reload
    tag = "R4";
    cyc(1, 1, 0, 8'h00, 0);
    chk("R4 no load", count, 0);
    cyc(1, 1, 0, 8'h10, 0);
    chk("R4 load", count, 32'h12345678);
    rd(0, 8'h10, "R4 load bit reads 1");

    // R3 byte order of live count
    rd(1, 8'h78, "R3 byte0");
    rd(2, 8'h56, "R3 byte1");
    rd(3, 8'h34, "R3 byte2");
    rd(4, 8'h12, "R3 byte3");
    rd(5, 8'h00, "R3 offset5");

    // R5 R6 run in test mode
    tag = "R6";
    cyc(1, 1, 0, 8'h02, 0);
    rd(0, 8'h12, "R10 run bit");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1);
    chk("R6 five steps", count, 32'h12345673);
    cyc(0, 0, 0, 0, 0);
    rd(1, 8'h73, "R3 live byte after steps");

    // R7 wrap at zero
    tag = "R7";
    cyc(1, 1, 1, 8'h03, 0);
    cyc(1, 1, 2, 8'h00, 0);
    cyc(1, 1, 3, 8'h00, 0);
    cyc(1, 1, 4, 8'h00, 0);
    cyc(1, 1, 0, 8'h12, 0);
    chk("R7 loaded", count, 3);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1);
    chk("R7 reached zero then reload", count, 3);
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, 0, (i % 2) == 0);

    // R11 load and tick together
    tag = "R11";
    cyc(0, 0, 0, 0, 1);
    cyc(1, 1, 0, 8'h12, 1);
    chk("R11 load wins", count, 3);

    // R5 stop again: run cleared halts
    tag = "R5";
    cyc(1, 1, 0, 8'h00, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1);
    chk("R5 halted again", count, 3);

    // R8 R9 operational mode
    tag = "R9";
    cyc(1, 1, 0, 8'h01, 0);
    rd(0, 8'h11, "R8 oper reads 1");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1);
    chk("R9 counts with run clear", count, 0);
    tag = "R8";
    cyc(1, 1, 0, 8'h00, 0);
    rd(0, 8'h11, "R8 clear ignored");
    cyc(0, 0, 0, 0, 1);
    chk("R8 still operational", count, 3);
    cyc(1, 1, 0, 8'hE2, 0);
    rd(0, 8'h13, "R10 reserved read 0");

    // R8 reset clears lock
    do_reset();
    tag = "R8";
    rd(0, 8'h10, "R8 reset clears oper");
    cyc(0, 0, 0, 0, 1);
    chk("R1 count after reset", count, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule